// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block gathers up to 32 interrupt sources into one interrupt request line for a processor. The low 16 sources come from inside the chip. The upper sources, up to 16 of them, come from outside the chip. Each source first passes through polarity normalization, which makes every source active-high. It is then captured into a sticky status word, either on a rising edge or for as long as its level stays high. A software-written enable word masks status to form the pending word. The interrupt line is high while any pending bit is set.

Software reads status, pending and enable, writes enable, and clears status through a write-one-to-clear acknowledge register. Polarity and trigger mode for the external sources are elaboration-time parameters. The internal sources are always rising-edge and active-high, whatever the external configuration says. All sources are assumed to be synchronous to the block clock. The asynchronous active-low reset is released to the logic through a two-stage synchronizer, so the block leaves reset two clock edges after the reset pin rises.

Top module: `intc_edge_level_ctrl`

## Requirements
- R1: After reset, the status, pending and enable registers all read 0 and `irq_o` is low.
- R2: Pending always equals status AND enable. `irq_o` is high exactly when any pending bit is set. A write to enable affects `irq_o` from the next clock cycle on.
- R3: An external source k whose `EXT_POS` bit is 0 is active-low: raw value 0 means asserted. When `EXT_POS` bit k is 1, raw value 1 means asserted. External source k appears at status bit 16+k.
- R4: An edge-mode source (`EXT_EDGE` bit 1) sets its status bit only when its normalized input goes from 0 to 1. Holding the input asserted after an acknowledge does not set the bit again.
- R5: A level-mode source (`EXT_EDGE` bit 0) sets its status bit on every cycle its normalized input is high. Acknowledging it while it is still asserted leaves the bit set. Acknowledging it after it is released clears the bit.
- R6: A write to acknowledge clears exactly the status bits written as 1. It never sets a bit, and it leaves bits written as 0 unchanged.
- R7: If a new event and an acknowledge of the same bit happen in the same cycle, the event wins and the status bit stays set.
- R8: Internal sources (status bits 15:0) are always rising-edge and active-high, whatever the values of `EXT_EDGE` and `EXT_POS`.
- R9: Bit positions in mask 0x40008787 are reserved. They never become set in status or enable, and they read as 0. Writing all ones to enable reads back 0xBFFF7878.
- R10: Status and pending are read-only. Bus writes to offsets 0x30 and 0x34 change nothing.
- R11: The register offsets are: status at 0x30, pending at 0x34, enable at 0x38 and acknowledge at 0x3C. Acknowledge and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| int_src_i | input | 16 | Internal interrupt sources, rising-edge, active-high |
| ext_src_i | input | NUM_EXT | External interrupt sources, polarity and mode set by parameters |
| reg_en_i | input | 1 | Register access strobe, one 32-bit access per cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request, OR of all pending bits |

## Verification
The bound checker watches four things on every cycle: the interrupt line against status and enable, the reserved bits staying clear, no status bit rising without a source event, and an acknowledge never beating a same-cycle event. Polarity inversion, the difference between edge and level capture, and the internal sources ignoring the external configuration can only be shown by the bench's scenarios, which drive chosen input patterns and read the registers back. The register map, the read-only behaviour of status and pending, and the enable read-back mask are likewise shown only through bus accesses in the bench.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int unsigned SRC_W     = 32;
  localparam int unsigned INT_SRC_N = 16;
  localparam int unsigned EXT_MAX   = 16;

  localparam logic [7:0] OFS_STATUS  = 8'h30;
  localparam logic [7:0] OFS_PENDING = 8'h34;
  localparam logic [7:0] OFS_ENABLE  = 8'h38;
  localparam logic [7:0] OFS_ACK     = 8'h3C;

  localparam logic [SRC_W-1:0] DEFAULT_RSVD = 32'h4000_8787;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_STATUS,
    RSEL_PENDING,
    RSEL_ENABLE,
    RSEL_ACK
  } rsel_e;

endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/intc_src_cond.sv
module intc_src_cond
  import intc_pkg::*;
#(
  parameter int unsigned      NUM_EXT   = 16,
  parameter logic [15:0]      EXT_EDGE  = 16'h0000,
  parameter logic [15:0]      EXT_POS   = 16'h0000,
  parameter logic [SRC_W-1:0] RSVD_MASK = DEFAULT_RSVD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] raw_i,
  output logic [SRC_W-1:0] evt_o
);

  // Internal sources are forced to rising-edge and active-high.
  localparam logic [SRC_W-1:0] EDGE_ALL = {EXT_EDGE, 16'hFFFF};
  localparam logic [SRC_W-1:0] POS_ALL  = {EXT_POS,  16'hFFFF};
  localparam int unsigned      LIVE_N   = INT_SRC_N + NUM_EXT;

  logic [SRC_W-1:0] norm;
  logic [SRC_W-1:0] norm_q;
  logic [SRC_W-1:0] norm_d;
  logic [SRC_W-1:0] evt_raw;
  logic [SRC_W-1:0] live_mask;

  for (genvar i = 0; i < SRC_W; i++) begin : g_src
    localparam bit IS_LIVE = (i < LIVE_N) && !RSVD_MASK[i];

    assign norm[i] = raw_i[i] ^ ~POS_ALL[i];

    if (EDGE_ALL[i]) begin : g_edge
      assign evt_raw[i] = norm[i] & ~norm_q[i];
    end else begin : g_level
      assign evt_raw[i] = norm[i];
    end

    assign live_mask[i] = IS_LIVE;
  end

  always_comb begin
    norm_d = norm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_q <= '0;
    end else begin
      norm_q <= norm_d;
    end
  end

  assign evt_o = evt_raw & live_mask;

endmodule

// File: rtl/intc_status_reg.sv
module intc_status_reg
  import intc_pkg::*;
#(
  parameter logic [SRC_W-1:0] RSVD_MASK = DEFAULT_RSVD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] evt_i,
  input  logic             ack_we_i,
  input  logic             en_we_i,
  input  logic [SRC_W-1:0] wdata_i,
  output logic [SRC_W-1:0] stat_o,
  output logic [SRC_W-1:0] en_o
);

  logic [SRC_W-1:0] stat_q, stat_d;
  logic [SRC_W-1:0] en_q, en_d;
  logic             stat_ce;
  logic             en_ce;

  always_comb begin
    stat_d = stat_q;
    if (ack_we_i) begin
      stat_d = stat_d & ~wdata_i;
    end
    // A new event is merged after the clear, so it wins over an acknowledge.
    stat_d  = stat_d | evt_i;
    stat_ce = ack_we_i | (|evt_i);

    en_d  = wdata_i & ~RSVD_MASK;
    en_ce = en_we_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      if (stat_ce) begin
        stat_q <= stat_d;
      end
      if (en_ce) begin
        en_q <= en_d;
      end
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;

endmodule

// File: rtl/intc_regif.sv
module intc_regif
  import intc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [SRC_W-1:0]  stat_i,
  input  logic [SRC_W-1:0]  pend_i,
  input  logic [SRC_W-1:0]  en_i,
  output logic              ack_we_o,
  output logic              en_we_o,
  output logic [SRC_W-1:0]  rdata_o
);

  rsel_e sel;

  always_comb begin
    if (reg_addr_i == ADDR_W'(OFS_STATUS)) begin
      sel = RSEL_STATUS;
    end else if (reg_addr_i == ADDR_W'(OFS_PENDING)) begin
      sel = RSEL_PENDING;
    end else if (reg_addr_i == ADDR_W'(OFS_ENABLE)) begin
      sel = RSEL_ENABLE;
    end else if (reg_addr_i == ADDR_W'(OFS_ACK)) begin
      sel = RSEL_ACK;
    end else begin
      sel = RSEL_NONE;
    end
  end

  always_comb begin
    ack_we_o = reg_en_i && reg_we_i && (sel == RSEL_ACK);
    en_we_o  = reg_en_i && reg_we_i && (sel == RSEL_ENABLE);
  end

  always_comb begin
    rdata_o = '0;
    if (reg_en_i && !reg_we_i) begin
      unique case (sel)
        RSEL_STATUS:  rdata_o = stat_i;
        RSEL_PENDING: rdata_o = pend_i;
        RSEL_ENABLE:  rdata_o = en_i;
        default:      rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/intc_edge_level_ctrl.sv
module intc_edge_level_ctrl
  import intc_pkg::*;
#(
  parameter int unsigned      NUM_EXT   = 16,        // 1..16
  parameter logic [15:0]      EXT_EDGE  = 16'h0000,  // 1 = edge, 0 = level
  parameter logic [15:0]      EXT_POS   = 16'h0000,  // 1 = active-high
  parameter logic [SRC_W-1:0] RSVD_MASK = DEFAULT_RSVD,
  parameter int unsigned      ADDR_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        int_src_i,
  input  logic [NUM_EXT-1:0] ext_src_i,
  input  logic               reg_en_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [SRC_W-1:0]   reg_wdata_i,
  output logic [SRC_W-1:0]   reg_rdata_o,
  output logic               irq_o
);

  logic             rst_sync_n;
  logic [SRC_W-1:0] raw_all;
  logic [SRC_W-1:0] evt;
  logic [SRC_W-1:0] stat_q;
  logic [SRC_W-1:0] en_q;
  logic [SRC_W-1:0] pend;
  logic             ack_we;
  logic             en_we;

  intc_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  always_comb begin
    raw_all                     = '0;
    raw_all[INT_SRC_N-1:0]      = int_src_i;
    raw_all[INT_SRC_N+:NUM_EXT] = ext_src_i;
  end

  intc_src_cond #(
    .NUM_EXT   (NUM_EXT),
    .EXT_EDGE  (EXT_EDGE),
    .EXT_POS   (EXT_POS),
    .RSVD_MASK (RSVD_MASK)
  ) u_src_cond (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .raw_i (raw_all),
    .evt_o (evt)
  );

  intc_status_reg #(
    .RSVD_MASK (RSVD_MASK)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt_i    (evt),
    .ack_we_i (ack_we),
    .en_we_i  (en_we),
    .wdata_i  (reg_wdata_i),
    .stat_o   (stat_q),
    .en_o     (en_q)
  );

  assign pend  = stat_q & en_q;
  assign irq_o = |pend;

  intc_regif #(
    .ADDR_W (ADDR_W)
  ) u_regif (
    .reg_en_i   (reg_en_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .stat_i     (stat_q),
    .pend_i     (pend),
    .en_i       (en_q),
    .ack_we_o   (ack_we),
    .en_we_o    (en_we),
    .rdata_o    (reg_rdata_o)
  );

endmodule

// File: rtl/intc_edge_level_ctrl_chk.sv
module intc_edge_level_ctrl_chk
  import intc_pkg::*;
#(
  parameter int unsigned      ADDR_W    = 8,
  parameter logic [SRC_W-1:0] RSVD_MASK = DEFAULT_RSVD
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_W-1:0]  evt,
  input logic [SRC_W-1:0]  stat_q,
  input logic [SRC_W-1:0]  en_q,
  input logic              irq_o,
  input logic              reg_en_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [SRC_W-1:0]  reg_wdata_i
);

  logic ack_wr;
  logic en_wr;

  assign ack_wr = reg_en_i && reg_we_i && (reg_addr_i == ADDR_W'(OFS_ACK));
  assign en_wr  = reg_en_i && reg_we_i && (reg_addr_i == ADDR_W'(OFS_ENABLE));

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q | en_q) & RSVD_MASK) == '0);                                   // R9

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(stat_q & en_q));                                             // R2

  AST_EN_ZERO_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && reg_wdata_i == '0) |=> !irq_o);                               // R2

  AST_SET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0) |=> ((stat_q & ~$past(stat_q)) == '0));                     // R6

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));                 // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> ((stat_q & $past(reg_wdata_i) & ~$past(evt)) == '0));        // R6

endmodule

bind intc_edge_level_ctrl intc_edge_level_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .RSVD_MASK (RSVD_MASK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .evt         (evt),
  .stat_q      (stat_q),
  .en_q        (en_q),
  .irq_o       (irq_o),
  .reg_en_i    (reg_en_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i)
);

// File: tb/intc_edge_level_ctrl_tb.sv
module intc_edge_level_ctrl_tb;

  localparam int unsigned NUM_EXT  = 16;
  localparam logic [15:0] EXT_EDGE = 16'h00FF;
  localparam logic [15:0] EXT_POS  = 16'h0F0F;
  localparam logic [31:0] RSVD     = 32'h4000_8787;
  localparam logic [31:0] EDGE_ALL = {EXT_EDGE, 16'hFFFF};
  localparam logic [31:0] POS_ALL  = {EXT_POS, 16'hFFFF};
  localparam logic [31:0] IDLE_RAW = {~EXT_POS, 16'h0000};
  localparam logic [7:0]  A_STAT   = 8'h30;
  localparam logic [7:0]  A_PEND   = 8'h34;
  localparam logic [7:0]  A_EN     = 8'h38;
  localparam logic [7:0]  A_ACK    = 8'h3C;

  logic        clk;
  logic        rst_n;
  logic [15:0] int_src;
  logic [15:0] ext_src;
  logic        reg_en;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  intc_edge_level_ctrl #(
    .NUM_EXT  (NUM_EXT),
    .EXT_EDGE (EXT_EDGE),
    .EXT_POS  (EXT_POS)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_src_i   (int_src),
    .ext_src_i   (ext_src),
    .reg_en_i    (reg_en),
    .reg_we_i    (reg_we),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int          errs   = 0;
  int          checks = 0;
  bit          done   = 0;
  logic [31:0] m_stat, m_en, m_prev, cur_raw;

  function automatic logic [31:0] f_norm(input logic [31:0] raw);
    return raw ^ ~POS_ALL;
  endfunction

  function automatic logic [31:0] f_evt(input logic [31:0] raw, input logic [31:0] prev);
    logic [31:0] n;
    n = f_norm(raw);
    return ((EDGE_ALL & n & ~prev) | (~EDGE_ALL & n)) & ~RSVD;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock cycle: drive at negedge, sample, advance the model past the posedge.
  task automatic cyc(input logic [31:0] raw, input bit en, input bit we,
                     input logic [7:0] addr, input logic [31:0] wd,
                     output logic [31:0] rd);
    logic [31:0] nst;
    @(negedge clk);
    cur_raw   = raw;
    int_src   = raw[15:0];
    ext_src   = raw[31:16];
    reg_en    = en;
    reg_we    = we;
    reg_addr  = addr;
    reg_wdata = wd;
    #1;
    rd = reg_rdata;
    check("R2 irq vs model", {31'b0, irq}, {31'b0, |(m_stat & m_en)});
    nst = m_stat;
    if (en && we && addr == A_ACK) nst = nst & ~wd;
    nst = nst | f_evt(raw, m_prev);
    if (en && we && addr == A_EN) m_en = wd & ~RSVD;
    m_prev = f_norm(raw);
    m_stat = nst;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    logic [31:0] d;
    for (int i = 0; i < n; i++) cyc(cur_raw, 0, 0, 8'h00, 32'h0, d);
  endtask

  task automatic setraw(input logic [31:0] raw);
    logic [31:0] d;
    cyc(raw, 0, 0, 8'h00, 32'h0, d);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] wd);
    logic [31:0] d;
    cyc(cur_raw, 1, 1, addr, wd, d);
  endtask

  task automatic rdchk(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    cyc(cur_raw, 1, 0, addr, 32'h0, d);
    check(tag, d, exp);
  endtask

  initial begin
    logic [31:0] d, exp, raw, wd;
    int unsigned op;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cur_raw = IDLE_RAW;
    int_src = IDLE_RAW[15:0];
    ext_src = IDLE_RAW[31:16];
    reg_en = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
    m_stat = '0; m_en = '0; m_prev = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R1: reset state
    rdchk(A_STAT, 32'h0, "R1 status after reset");
    rdchk(A_PEND, 32'h0, "R1 pending after reset");
    rdchk(A_EN,   32'h0, "R1 enable after reset");
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R11: map
    rdchk(A_ACK, 32'h0, "R11 acknowledge reads zero");
    rdchk(8'h00, 32'h0, "R11 unmapped reads zero");

    // R8: internal source 3, edge only
    setraw(IDLE_RAW | 32'h8);
    rdchk(A_STAT, 32'h8, "R8 internal rising edge sets");
    wr(A_ACK, 32'h8);
    idle(2);
    rdchk(A_STAT, 32'h0, "R8 internal held high does not re-set");
    setraw(IDLE_RAW);

    // R4: external 0, edge, active-high
    setraw(IDLE_RAW | 32'h0001_0000);
    rdchk(A_STAT, 32'h0001_0000, "R4 edge source sets");
    wr(A_ACK, 32'h0001_0000);
    idle(2);
    rdchk(A_STAT, 32'h0, "R4 edge held after ack stays clear");
    setraw(IDLE_RAW);

    // R3: external 4, edge, active-low
    setraw(IDLE_RAW & ~32'h0010_0000);
    rdchk(A_STAT, 32'h0010_0000, "R3 active-low source sets on low");
    setraw(IDLE_RAW);
    wr(A_ACK, 32'h0010_0000);
    rdchk(A_STAT, 32'h0, "R3 cleared after release");

    // R5: external 8, level, active-high
    setraw(IDLE_RAW | 32'h0100_0000);
    wr(A_ACK, 32'h0100_0000);
    idle(1);
    rdchk(A_STAT, 32'h0100_0000, "R5 level ack while asserted stays set");
    setraw(IDLE_RAW);
    wr(A_ACK, 32'h0100_0000);
    rdchk(A_STAT, 32'h0, "R5 level ack after release clears");

    // R7: event and ack same cycle
    setraw(IDLE_RAW | 32'h0002_0000);
    setraw(IDLE_RAW);
    cyc(IDLE_RAW | 32'h0002_0000, 1, 1, A_ACK, 32'h0002_0000, d);
    rdchk(A_STAT, 32'h0002_0000, "R7 event wins over ack");
    wr(A_ACK, 32'h0002_0000);
    setraw(IDLE_RAW);

    // R6: ack never sets, only written ones clear
    wr(A_ACK, 32'hFFFF_FFFF);
    rdchk(A_STAT, 32'h0, "R6 ack of clear bits sets nothing");
    setraw(IDLE_RAW | 32'h0006_0000);
    setraw(IDLE_RAW);
    wr(A_ACK, 32'h0002_0000);
    rdchk(A_STAT, 32'h0004_0000, "R6 partial ack");

    // R2: pending and irq
    wr(A_EN, 32'h0004_0000);
    rdchk(A_PEND, 32'h0004_0000, "R2 pending = status & enable");
    check("R2 irq high with pending", {31'b0, irq}, 32'h1);
    wr(A_EN, 32'h0002_0000);
    rdchk(A_PEND, 32'h0, "R2 pending masked");
    check("R2 irq low when masked", {31'b0, irq}, 32'h0);

    // R10: status/pending read-only
    wr(A_STAT, 32'h0);
    rdchk(A_STAT, 32'h0004_0000, "R10 write to status ignored");
    wr(A_PEND, 32'hFFFF_FFFF);
    wr(A_STAT, 32'hFFFF_FFFF);
    rdchk(A_STAT, 32'h0004_0000, "R10 writes do not set status");
    wr(A_ACK, 32'h0004_0000);
    wr(A_EN, 32'h0);

    // R9: reserved positions
    setraw((IDLE_RAW | 32'h0000_8001) & ~32'h4000_0000);
    idle(2);
    rdchk(A_STAT, 32'h0, "R9 reserved sources never set");
    wr(A_EN, 32'hFFFF_FFFF);
    rdchk(A_EN, 32'hBFFF_7878, "R9 enable reserved bits read zero");
    setraw(IDLE_RAW);
    wr(A_EN, 32'h0);

    // Random phase against the model
    for (int n = 0; n < 4000; n++) begin
      raw = cur_raw ^ ($urandom & $urandom & $urandom);
      op  = $urandom % 8;
      wd  = $urandom;
      case (op)
        0: cyc(raw, 1, 1, A_EN, wd, d);
        1: cyc(raw, 1, 1, A_ACK, wd | $urandom, d);
        2: begin exp = m_stat; cyc(raw, 1, 0, A_STAT, 32'h0, d); check("R5 random status", d, exp); end
        3: begin exp = m_stat & m_en; cyc(raw, 1, 0, A_PEND, 32'h0, d); check("R2 random pending", d, exp); end
        4: begin exp = m_en; cyc(raw, 1, 0, A_EN, 32'h0, d); check("R9 random enable", d, exp); end
        default: cyc(raw, 0, 0, 8'h00, 32'h0, d);
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule